// File: doc/BRIEF.md
# Two-Lane Sample Boundary Aligner

This block rebuilds 14-bit converter samples from two serial lanes. Each lane has already been eye-centred and arrives as one 7-bit parallel word per sample clock. The word boundary is still unknown, and one lane may run a whole sample ahead of the other. The upper lane (`lane0_i`) carries sample bits 13..7 and the lower lane (`lane1_i`) carries bits 6..0. The converter's own frame clock is not used, because its skew to the data can change sign from one power-up to the next. Alignment is therefore found from the data itself.

Training runs in three phases, and the `mode_i` input says which phase the converter is in:

- **Word-boundary phase.** The converter sends the sync word 0x3C78, which appears as 1111000 on each lane. A per-lane gearbox shifts its bit window until that word repeats.
- **Ramp phase.** The converter sends an incrementing ramp. A state machine tries three lane-delay settings until successive rebuilt samples rise by one. It then confirms the chosen setting over a long run of the ramp.
- **Data phase.** Live samples are forwarded with a valid flag.

The state machine has six states:

| State | Code | Meaning |
|---|---|---|
| IDLE | 0 | Waiting for training to start |
| HUNT | 1 | Gearboxes search for the word boundary |
| SKEW | 2 | Lane-delay settings are tried against the ramp |
| VERIFY | 3 | The chosen setting is confirmed over the ramp |
| LOCKED | 4 | Samples are valid |
| FAIL | 5 | A lane found no word boundary |

Its transitions are:

- IDLE→HUNT when the mode becomes sync.
- HUNT→SKEW when both lanes lock.
- HUNT→FAIL when either lane reports a sync error.
- SKEW→VERIFY after a short trial run of correct increments.
- VERIFY→LOCKED after the full ramp count.
- VERIFY→SKEW or LOCKED→SKEW on any ramp mismatch, with the next delay setting.
- Any state→IDLE when the mode returns to idle.

Top module: `two_lane_aligner`

## Requirements
- R1: After reset, `phase_o`=0 (IDLE), `valid_o`=0, `lane_lock_o`=0, `lane_err_o`=0 and `skew_o`=0.
- R2: Mode codes on `mode_i` are 0 idle, 1 sync, 2 ramp and 3 data. In HUNT, each lane compares its current 7-bit window with 1111000 once per cycle. Each lane advances its window by one bit on every mismatch. A lane sets its `lane_lock_o` bit only after 8 consecutive matches. It is therefore never locked in the first 8 cycles after mode 1 is applied. With a steady sync word it is locked within 20 cycles, and the phase is then 2 (SKEW).
- R3: A lane that fails at all 7 window positions sets its `lane_err_o` bit. The phase then becomes 5 (FAIL) and stays there with `valid_o` low until mode 0 is applied.
- R4: The output sample is {upper-lane word, lower-lane word}. Once locked, the data-mode samples leave in the order they were sent, with the lane offset removed.
- R5: `skew_o` codes are 0 for no delay, 1 for the upper lane delayed by one sample, and 2 for the lower lane delayed by one sample. Settings are tried in the order 0, 1, 2, then 0 again. Lanes with equal latency end at 0. A late lower lane ends at 1, and a late upper lane ends at 2.
- R6: In SKEW, 4 correct increments are needed after one settling cycle. In VERIFY, 1024 consecutive samples must each exceed the previous one by exactly 1 modulo 2^14. `valid_o` rises in the cycle after the last of these. While valid in ramp mode, every sample is the previous one plus 1.
- R7: A ramp mismatch in VERIFY, or in LOCKED with mode 2, moves to SKEW with the next setting. In LOCKED, `valid_o` drops in the same cycle as the mismatching sample.
- R8: `valid_o` is low in every state other than LOCKED.
- R9: Mode 0 sets the phase to IDLE at the next clock edge from any state. Lock and error flags clear one cycle later.
- R10: In data mode (3), samples are not checked and `valid_o` stays high while in LOCKED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Training phase: 0 idle, 1 sync, 2 ramp, 3 data |
| lane0_i | input | 7 | Raw parallel word of the upper lane |
| lane1_i | input | 7 | Raw parallel word of the lower lane |
| sample_o | output | 14 | Rebuilt sample |
| valid_o | output | 1 | Sample usable |
| lane_lock_o | output | 2 | Per-lane word-boundary lock (bit 0 is the upper lane) |
| lane_err_o | output | 2 | Per-lane sync error |
| skew_o | output | 2 | Chosen lane-delay setting |
| phase_o | output | 3 | State code |

## Verification
The assertions are checked on every cycle:

- `valid_o` is high only in LOCKED.
- `valid_o` can rise only when coming out of VERIFY.
- A valid ramp sample always exceeds its predecessor by one.
- Mode 0 forces IDLE on the next cycle.
- A sync error excludes validity.
- No reserved skew code appears.
- A lane lock can only rise during HUNT.

Only the bench scenarios can show the following:

- That the lock appears neither too early nor too late.
- That the chosen skew setting matches a deliberately delayed lane.
- That the ramp phase lasts at least the full confirmation count.
- That a glitch forces a new search.
- That live samples come out intact and in order.

// File: rtl/tla_pkg.sv
package tla_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_HUNT   = 3'd1,
        PH_SKEW   = 3'd2,
        PH_VERIFY = 3'd3,
        PH_LOCKED = 3'd4,
        PH_FAIL   = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        MD_IDLE = 2'd0,
        MD_SYNC = 2'd1,
        MD_RAMP = 2'd2,
        MD_DATA = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        SK_NONE    = 2'd0,
        SK_HI_LATE = 2'd1,
        SK_LO_LATE = 2'd2
    } skew_e;

    function automatic skew_e skew_next(input skew_e cur);
        skew_e nxt;
        unique case (cur)
            SK_NONE:    nxt = SK_HI_LATE;
            SK_HI_LATE: nxt = SK_LO_LATE;
            default:    nxt = SK_NONE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/tla_gearbox.sv
module tla_gearbox #(
    parameter int               LANE_W   = 7,
    parameter logic [LANE_W-1:0] SYNC_PAT = '0,
    parameter int               MATCH_N  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              hunt,
    input  logic [LANE_W-1:0] raw_i,
    output logic [LANE_W-1:0] word_o,
    output logic              locked_o,
    output logic              err_o
);
    localparam int SLIP_W = $clog2(LANE_W);
    localparam int CNT_W  = $clog2(MATCH_N + 1);

    logic [2*LANE_W-1:0] cat;
    logic [LANE_W-1:0]   prev_q;
    logic [LANE_W-1:0]   win;
    logic [LANE_W-1:0]   word_q;
    logic [SLIP_W-1:0]   slip_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                locked_q;
    logic                err_q;

    assign cat = {prev_q, raw_i};
    assign win = cat[slip_q +: LANE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            word_q   <= '0;
            slip_q   <= '0;
            cnt_q    <= '0;
            locked_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            prev_q <= raw_i;
            word_q <= win;
            if (clear) begin
                slip_q   <= '0;
                cnt_q    <= '0;
                locked_q <= 1'b0;
                err_q    <= 1'b0;
            end else if (hunt && !locked_q && !err_q) begin
                if (win == SYNC_PAT) begin
                    if (cnt_q == CNT_W'(MATCH_N - 1)) begin
                        locked_q <= 1'b1;
                    end
                    cnt_q <= cnt_q + 1'b1;
                end else begin
                    cnt_q <= '0;
                    if (slip_q == SLIP_W'(LANE_W - 1)) begin
                        err_q <= 1'b1;
                    end else begin
                        slip_q <= slip_q + 1'b1;
                    end
                end
            end
        end
    end

    assign word_o   = word_q;
    assign locked_o = locked_q;
    assign err_o    = err_q;

endmodule

// File: rtl/tla_deskew.sv
module tla_deskew #(
    parameter int LANE_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANE_W-1:0]   hi_i,
    input  logic [LANE_W-1:0]   lo_i,
    input  logic [1:0]          sel_i,
    output logic [2*LANE_W-1:0] sample_o,
    output logic                step_ok_o
);
    localparam int SAMPLE_W = 2 * LANE_W;

    logic [LANE_W-1:0]   hi_d;
    logic [LANE_W-1:0]   lo_d;
    logic [SAMPLE_W-1:0] prev_q;
    logic [SAMPLE_W-1:0] smp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_d   <= '0;
            lo_d   <= '0;
            prev_q <= '0;
        end else begin
            hi_d   <= hi_i;
            lo_d   <= lo_i;
            prev_q <= smp;
        end
    end

    always_comb begin
        case (sel_i)
            2'd1:    smp = {hi_d, lo_i};
            2'd2:    smp = {hi_i, lo_d};
            default: smp = {hi_i, lo_i};
        endcase
    end

    assign sample_o  = smp;
    assign step_ok_o = (smp == SAMPLE_W'(prev_q + 1'b1));

endmodule

// File: rtl/two_lane_aligner.sv
module two_lane_aligner
    import tla_pkg::*;
#(
    parameter int                   LANE_W    = 7,
    parameter logic [2*LANE_W-1:0]  SYNC_WORD = 14'h3C78,
    parameter int                   MATCH_N   = 8,
    parameter int                   TRIAL_LEN = 4,
    parameter int                   RAMP_LEN  = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_i,
    input  logic [LANE_W-1:0]   lane0_i,
    input  logic [LANE_W-1:0]   lane1_i,
    output logic [2*LANE_W-1:0] sample_o,
    output logic                valid_o,
    output logic [1:0]          lane_lock_o,
    output logic [1:0]          lane_err_o,
    output logic [1:0]          skew_o,
    output logic [2:0]          phase_o
);
    localparam int SAMPLE_W = 2 * LANE_W;
    localparam int CNT_W    = $clog2(RAMP_LEN + 1);

    mode_e                    mode;
    phase_e                   state_q, state_d;
    skew_e                    sel_q;
    logic [CNT_W-1:0]         cnt_q;
    logic                     settle_q;
    logic [1:0][LANE_W-1:0]   raw_w;
    logic [1:0][LANE_W-1:0]   word_w;
    logic [1:0]               lock;
    logic [1:0]               err;
    logic [SAMPLE_W-1:0]      smp;
    logic                     step_ok;

    assign mode     = mode_e'(mode_i);
    assign raw_w[0] = lane0_i;
    assign raw_w[1] = lane1_i;

    // One gearbox per lane; the upper lane hunts for the upper half of the sync word.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam logic [LANE_W-1:0] PAT = (g == 0) ? SYNC_WORD[SAMPLE_W-1 -: LANE_W]
                                                     : SYNC_WORD[LANE_W-1:0];
        tla_gearbox #(
            .LANE_W  (LANE_W),
            .SYNC_PAT(PAT),
            .MATCH_N (MATCH_N)
        ) u_gb (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (state_q == PH_IDLE),
            .hunt    (state_q == PH_HUNT),
            .raw_i   (raw_w[g]),
            .word_o  (word_w[g]),
            .locked_o(lock[g]),
            .err_o   (err[g])
        );
    end

    tla_deskew #(.LANE_W(LANE_W)) u_dsk (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_i     (word_w[0]),
        .lo_i     (word_w[1]),
        .sel_i    (sel_q),
        .sample_o (smp),
        .step_ok_o(step_ok)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (mode == MD_IDLE) begin
            state_d = PH_IDLE;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    if (mode == MD_SYNC) state_d = PH_HUNT;
                end
                PH_HUNT: begin
                    if (|err)       state_d = PH_FAIL;
                    else if (&lock) state_d = PH_SKEW;
                end
                PH_SKEW: begin
                    if (mode == MD_RAMP && !settle_q && step_ok &&
                        cnt_q == CNT_W'(TRIAL_LEN - 1))
                        state_d = PH_VERIFY;
                end
                PH_VERIFY: begin
                    if (mode == MD_RAMP) begin
                        if (!step_ok)                          state_d = PH_SKEW;
                        else if (cnt_q == CNT_W'(RAMP_LEN - 1)) state_d = PH_LOCKED;
                    end
                end
                PH_LOCKED: begin
                    if (mode == MD_RAMP && !step_ok) state_d = PH_SKEW;
                end
                PH_FAIL: begin
                    state_d = PH_FAIL;
                end
                default: state_d = PH_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // Trial / confirmation counter and lane-delay setting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            settle_q <= 1'b1;
            sel_q    <= SK_NONE;
        end else if (state_d != state_q) begin
            cnt_q    <= '0;
            settle_q <= 1'b1;
            if (state_d == PH_SKEW)
                sel_q <= (state_q == PH_HUNT) ? SK_NONE : skew_next(sel_q);
            else if (state_d == PH_IDLE)
                sel_q <= SK_NONE;
        end else if (mode == MD_RAMP) begin
            if (state_q == PH_SKEW) begin
                if (settle_q) begin
                    settle_q <= 1'b0;
                end else if (step_ok) begin
                    cnt_q <= cnt_q + 1'b1;
                end else begin
                    sel_q    <= skew_next(sel_q);
                    settle_q <= 1'b1;
                    cnt_q    <= '0;
                end
            end else if (state_q == PH_VERIFY) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        sample_o    = smp;
        valid_o     = (state_q == PH_LOCKED) && !(mode == MD_RAMP && !step_ok);
        lane_lock_o = lock;
        lane_err_o  = err;
        skew_o      = sel_q;
        phase_o     = state_q;
    end

endmodule

// File: rtl/two_lane_aligner_chk.sv
module two_lane_aligner_chk #(
    parameter int SAMPLE_W = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          mode_i,
    input logic [SAMPLE_W-1:0] sample_o,
    input logic                valid_o,
    input logic [1:0]          lane_lock_o,
    input logic [1:0]          lane_err_o,
    input logic [1:0]          skew_o,
    input logic [2:0]          phase_o
);
    // R8
    valid_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> phase_o == 3'd4);

    // R6
    valid_rise_after_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(phase_o) == 3'd3);

    // R6
    ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && mode_i == 2'd2) |-> sample_o == SAMPLE_W'($past(sample_o) + 1'b1));

    // R9
    idle_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == 2'd0 |=> (phase_o == 3'd0 && !valid_o));

    // R3
    err_blocks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_err_o) |-> !valid_o);

    // R5
    skew_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skew_o != 2'd3);

    // R2
    lock_in_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_lock_o[0]) |-> $past(phase_o) == 3'd1);

endmodule

bind two_lane_aligner two_lane_aligner_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .sample_o   (sample_o),
    .valid_o    (valid_o),
    .lane_lock_o(lane_lock_o),
    .lane_err_o (lane_err_o),
    .skew_o     (skew_o),
    .phase_o    (phase_o)
);

// File: tb/sim_two_lane_aligner.sv
module sim_two_lane_aligner;

    localparam int RAMP_LEN  = 1024;
    localparam int TRIAL_LEN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [6:0]  l0 = '0, l1 = '0;
    logic [13:0] sample_o;
    logic        valid_o;
    logic [1:0]  lane_lock_o, lane_err_o, skew_o;
    logic [2:0]  phase_o;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    logic [13:0] exp_q[$];
    int          d0 = 0, d1 = 0;
    bit          wd0 = 0, wd1 = 0;
    logic [6:0]  hold0 = '0, hold1 = '0;
    logic [13:0] sr0 = '0, sr1 = '0;
    logic [13:0] ramp_v = 14'h3F80;
    bit          data_on = 0;

    two_lane_aligner u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .lane0_i(l0), .lane1_i(l1),
        .sample_o(sample_o), .valid_o(valid_o), .lane_lock_o(lane_lock_o),
        .lane_err_o(lane_err_o), .skew_o(skew_o), .phase_o(phase_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Driver: splits a sample over the lanes, applies word and bit delays.
    task automatic push(input logic [13:0] s);
        logic [6:0] w0, w1;
        w0 = wd0 ? hold0 : s[13:7];
        hold0 = s[13:7];
        w1 = wd1 ? hold1 : s[6:0];
        hold1 = s[6:0];
        sr0 = {sr0[6:0], w0};
        sr1 = {sr1[6:0], w1};
        l0 = sr0[d0 +: 7];
        l1 = sr1[d1 +: 7];
        if (data_on) exp_q.push_back(s);
        @(negedge clk);
    endtask

    task automatic ramp_until_valid(output int n);
        n = 0;
        while (!valid_o && n < 4000) begin
            push(ramp_v);
            ramp_v = ramp_v + 14'd1;
            n++;
        end
    endtask

    task automatic train(input int a, input int b, input bit x, input bit y, input int exp_skew);
        int n;
        d0 = a; d1 = b; wd0 = x; wd1 = y;
        mode = 2'd0;
        repeat (4) push(14'h3C78);
        mode = 2'd1;
        repeat (8) push(14'h3C78);
        check(lane_lock_o == 2'b00, "R2", "lock before eight matches", lane_lock_o, 0);
        repeat (12) push(14'h3C78);
        check(lane_lock_o == 2'b11, "R2", "lock after sync", lane_lock_o, 3);
        check(phase_o == 3'd2, "R2", "phase after lock", phase_o, 2);
        check(!valid_o, "R8", "valid during training", valid_o, 0);
        mode = 2'd2;
        ramp_until_valid(n);
        check(valid_o, "R6", "valid after ramp", valid_o, 1);
        check(n >= RAMP_LEN + TRIAL_LEN, "R6", "ramp cycles lower bound", n, RAMP_LEN + TRIAL_LEN);
        check(n <= RAMP_LEN + 600, "R6", "ramp cycles upper bound", n, RAMP_LEN + 600);
        if (exp_skew >= 0)
            check(skew_o == exp_skew[1:0], "R5", "lane delay setting", skew_o, exp_skew);
    endtask

    task automatic data_run(input int n);
        exp_q.delete();
        data_on = 1;
        mode = 2'd3;
        for (int i = 0; i < n; i++) push(14'($urandom));
        check(valid_o, "R10", "valid held in data mode", valid_o, 1);
        data_on = 0;
    endtask

    // Monitor / scoreboard
    bit          pv_valid = 0;
    logic [1:0]  pv_mode = 0;
    logic [13:0] pv_sample = 0;
    int          data_age = 0;
    bit          synced = 0;

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (valid_o && phase_o != 3'd4)
                check(0, "R8", "valid outside LOCKED", phase_o, 4);
            if (valid_o && mode == 2'd2 && pv_valid && pv_mode == 2'd2)
                check(sample_o == 14'(pv_sample + 14'd1), "R6", "ramp step", sample_o,
                      14'(pv_sample + 14'd1));
            if (mode == 2'd3 && data_on) begin
                data_age++;
                if (data_age >= 4) begin
                    if (!valid_o) begin
                        check(0, "R10", "valid dropped in data mode", valid_o, 1);
                    end else begin
                        if (!synced) begin
                            for (int k = 0; k < 8; k++)
                                if (exp_q.size() > 0 && exp_q[0] != sample_o) void'(exp_q.pop_front());
                            synced = 1;
                        end
                        if (exp_q.size() == 0) begin
                            check(0, "R4", "scoreboard empty", sample_o, 0);
                        end else begin
                            check(exp_q[0] == sample_o, "R4", "data sample", sample_o, exp_q[0]);
                            void'(exp_q.pop_front());
                        end
                    end
                end
            end else begin
                data_age = 0;
                synced = 0;
            end
            pv_valid  = valid_o;
            pv_mode   = mode;
            pv_sample = sample_o;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            check(0, "R6", "watchdog expired", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit saw_drop, saw_skew;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(phase_o == 3'd0, "R1", "phase", phase_o, 0);
        check(!valid_o, "R1", "valid", valid_o, 0);
        check(lane_lock_o == 2'b00, "R1", "lock", lane_lock_o, 0);
        check(lane_err_o == 2'b00, "R1", "err", lane_err_o, 0);
        check(skew_o == 2'd0, "R1", "skew", skew_o, 0);

        // Equal lanes, bit delay 3: R2 R5 R6
        train(3, 3, 0, 0, 0);

        // R7: inject a ramp glitch while locked
        saw_drop = 0; saw_skew = 0;
        push(14'(ramp_v + 14'd100));
        ramp_v = ramp_v + 14'd1;
        for (int i = 0; i < 6; i++) begin
            if (!valid_o) saw_drop = 1;
            if (phase_o == 3'd2) saw_skew = 1;
            push(ramp_v);
            ramp_v = ramp_v + 14'd1;
        end
        check(saw_drop, "R7", "valid cleared by glitch", saw_drop, 1);
        check(saw_skew, "R7", "search restarted", saw_skew, 1);
        ramp_until_valid(n);
        check(valid_o, "R7", "relock after glitch", valid_o, 1);
        check(skew_o == 2'd0, "R5", "setting after relock", skew_o, 0);

        // R4 R10 live data
        data_run(200);

        // R9 return to idle
        mode = 2'd0;
        push(14'h3C78);
        check(phase_o == 3'd0, "R9", "phase after mode 0", phase_o, 0);
        push(14'h3C78);
        check(lane_lock_o == 2'b00, "R9", "lock cleared", lane_lock_o, 0);

        // Lower lane late -> setting 1; upper lane late -> setting 2
        train(2, 2, 0, 1, 1);
        train(5, 5, 1, 0, 2);

        // Unequal bit delays, then data
        train(1, 6, 0, 0, -1);
        data_run(100);

        // R3 no boundary found
        mode = 2'd0;
        repeat (4) push(14'h2AAA);
        mode = 2'd1;
        repeat (14) push(14'h2AAA);
        check(lane_err_o == 2'b11, "R3", "sync error", lane_err_o, 3);
        check(phase_o == 3'd5, "R3", "phase FAIL", phase_o, 5);
        check(!valid_o, "R3", "valid in FAIL", valid_o, 0);
        mode = 2'd0;
        push(14'h2AAA);
        push(14'h2AAA);
        check(lane_err_o == 2'b00, "R9", "error cleared", lane_err_o, 0);
        check(phase_o == 3'd0, "R9", "phase after FAIL", phase_o, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule